// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the program counter of a single-cycle processor core and picks the address of the next instruction on every clock edge. It chooses from three candidates. The first is the sequential address, four bytes past the current one. The second is a PC-relative conditional branch target. The third is a region-relative (pseudo-direct) jump target.

The decode stage supplies the fields and flags of the current instruction:

- the 16-bit branch displacement;
- the 26-bit jump field;
- a two-bit branch kind;
- a jump flag.

The ALU supplies its zero flag from the operand comparison.

The block exports the current PC for instruction fetch. It also exports the sequential address, which the register-file writeback path uses as the return-link value.

The branch kind has bit 1 set for a conditional branch. Bit 0 then selects equality (0) or inequality (1) against the zero flag. A set jump flag overrides any branch decision.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0 at the next rising edge. While held, the PC stays 0 and the link output reads 4.
- R2: The link output `pc_link` always equals `pc_q` + 4 (modulo 2^32), in the same cycle as `pc_q`.
- R3: With the jump flag low and a branch kind of 2'b00 or 2'b01, the PC becomes `pc_q` + 4 at the next edge, whatever the zero flag is.
- R4: Branch kind 2'b10 (equal) with zero = 1 and the jump flag low loads `pc_q` + 4 + (sign-extended displacement × 4).
- R5: Branch kind 2'b10 with zero = 0 loads the sequential address.
- R6: Branch kind 2'b11 (not equal) loads the branch target when zero = 0 and the sequential address when zero = 1.
- R7: The displacement is sign-extended from bit 15, so 16'hFFFF gives a target equal to the current PC, and negative offsets move backwards.
- R8: A jump loads {`pc_q`[31:28], jump field, 2'b00}. The upper four bits come from the PC of the jump itself, not from the sequential address.
- R9: When the jump flag is high, the jump target is loaded even if the branch condition holds.
- R10: The sequential increment carries across the 256 MiB region boundary, so 32'h0FFFFFFC is followed by 32'h10000000, and later jumps keep the new upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| br_disp | input | 16 | Branch displacement field, in words |
| jmp_field | input | 26 | Jump target field, in words |
| br_kind | input | 2 | 00/01 none, 10 branch if equal, 11 branch if not equal |
| jmp_en | input | 1 | Take the pseudo-direct jump |
| alu_zero | input | 1 | ALU zero flag from the operand comparison |
| pc_q | output | 32 | Current program counter |
| pc_link | output | 32 | Current PC plus 4, for link writeback |

## Verification
The inputs that go with a given PC produce their result in `pc_q` exactly one rising edge later. `pc_link` follows `pc_q` combinationally in the same cycle. The driver applies each instruction's fields on the falling edge. In the same pass it checks `pc_link` against its own model PC, and it queues the address it expects after the coming edge. The monitor wakes 2 ns after each rising edge, pops one entry and compares it with `pc_q`, so every expected value lines up with the single register stage in the path.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int ADDR_W_D = 32;
  localparam int DISP_W_D = 16;
  localparam int JFLD_W_D = 26;

  localparam logic [1:0] KIND_EQ = 2'b10;
  localparam logic [1:0] KIND_NE = 2'b11;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'b00,
    SRC_BRANCH = 2'b01,
    SRC_JUMP   = 2'b10
  } next_src_e;
endpackage

// File: rtl/pcu_branch_decide.sv
module pcu_branch_decide (
  input  logic [1:0] br_kind,
  input  logic       alu_zero,
  output logic       taken
);
  import pcu_pkg::*;

  always_comb begin
    unique case (br_kind)
      KIND_EQ: taken = alu_zero;
      KIND_NE: taken = ~alu_zero;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcu_target_calc.sv
module pcu_target_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int JFLD_W = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [JFLD_W-1:0] jfld,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] br_addr,
  output logic [ADDR_W-1:0] jmp_addr
);
  localparam int EXT_W = ADDR_W - DISP_W - 2;
  localparam int HI_W  = ADDR_W - JFLD_W - 2;

  function automatic logic [ADDR_W-1:0] f_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(4);
  endfunction

  function automatic logic [ADDR_W-1:0] f_word_off(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] f_region(input logic [ADDR_W-1:0] a,
                                                 input logic [JFLD_W-1:0] f);
    return {a[ADDR_W-1 -: HI_W], f, 2'b00};
  endfunction

  assign seq_addr = f_step(pc);
  assign br_addr  = seq_addr + f_word_off(disp);
  assign jmp_addr = f_region(pc, jfld);
endmodule

// File: rtl/pcu_next_select.sv
module pcu_next_select #(
  parameter int ADDR_W = 32
) (
  input  logic                jmp_en,
  input  logic                taken,
  input  logic [ADDR_W-1:0]   seq_addr,
  input  logic [ADDR_W-1:0]   br_addr,
  input  logic [ADDR_W-1:0]   jmp_addr,
  output pcu_pkg::next_src_e  src,
  output logic [ADDR_W-1:0]   next_pc
);
  import pcu_pkg::*;

  always_comb begin
    if (jmp_en)     src = SRC_JUMP;
    else if (taken) src = SRC_BRANCH;
    else            src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JUMP:   next_pc = jmp_addr;
      SRC_BRANCH: next_pc = br_addr;
      default:    next_pc = seq_addr;
    endcase
  end
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] next_pc,
  output logic [ADDR_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst) pc <= ADDR_W'(RESET_PC);
    else     pc <= next_pc;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int ADDR_W = pcu_pkg::ADDR_W_D,
  parameter int DISP_W = pcu_pkg::DISP_W_D,
  parameter int JFLD_W = pcu_pkg::JFLD_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DISP_W-1:0] br_disp,
  input  logic [JFLD_W-1:0] jmp_field,
  input  logic [1:0]        br_kind,
  input  logic              jmp_en,
  input  logic              alu_zero,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] pc_link
);
  // internal events brought out by name for the checker
  logic               br_taken;
  pcu_pkg::next_src_e nsrc;
  logic [ADDR_W-1:0]  seq_addr;
  logic [ADDR_W-1:0]  br_addr;
  logic [ADDR_W-1:0]  jmp_addr;
  logic [ADDR_W-1:0]  next_pc;

  pcu_branch_decide u_dec (
    .br_kind (br_kind),
    .alu_zero(alu_zero),
    .taken   (br_taken)
  );

  pcu_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .JFLD_W(JFLD_W)) u_tgt (
    .pc      (pc_q),
    .disp    (br_disp),
    .jfld    (jmp_field),
    .seq_addr(seq_addr),
    .br_addr (br_addr),
    .jmp_addr(jmp_addr)
  );

  pcu_next_select #(.ADDR_W(ADDR_W)) u_sel (
    .jmp_en  (jmp_en),
    .taken   (br_taken),
    .seq_addr(seq_addr),
    .br_addr (br_addr),
    .jmp_addr(jmp_addr),
    .src     (nsrc),
    .next_pc (next_pc)
  );

  pcu_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .next_pc(next_pc),
    .pc     (pc_q)
  );

  assign pc_link = seq_addr;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int JFLD_W = 26
) (
  input logic               clk,
  input logic               rst,
  input logic [DISP_W-1:0]  br_disp,
  input logic [JFLD_W-1:0]  jmp_field,
  input logic [1:0]         br_kind,
  input logic               jmp_en,
  input logic               alu_zero,
  input logic [ADDR_W-1:0]  pc_q,
  input logic [ADDR_W-1:0]  pc_link,
  input logic               br_taken,
  input pcu_pkg::next_src_e nsrc
);
  import pcu_pkg::*;
  localparam int EXT_W = ADDR_W - DISP_W - 2;
  localparam int HI_W  = ADDR_W - JFLD_W - 2;

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    // R1
    if (rst_seen) reset_value_chk: assert (pc_q == '0);
  end

  // R3
  seq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && !br_kind[1]) |=> pc_q == $past(pc_link));

  // R4
  eq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && br_kind == KIND_EQ && alu_zero) |=>
      pc_q == $past(pc_link) + {{EXT_W{$past(br_disp[DISP_W-1])}}, $past(br_disp), 2'b00});

  // R6
  ne_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && br_kind == KIND_NE && !alu_zero) |=>
      pc_q == $past(pc_link) + {{EXT_W{$past(br_disp[DISP_W-1])}}, $past(br_disp), 2'b00});

  // R5
  eq_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (br_kind == KIND_EQ && !alu_zero) |-> !br_taken);

  // R8
  jump_form_chk: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> (pc_q[1:0] == 2'b00 &&
                pc_q[ADDR_W-1 -: HI_W] == $past(pc_q[ADDR_W-1 -: HI_W]) &&
                pc_q[ADDR_W-HI_W-1:2] == $past(jmp_field)));

  // R9
  jump_wins_chk: assert property (@(posedge clk) disable iff (rst)
    jmp_en |-> nsrc == SRC_JUMP);

  // R2
  link_step_chk: assert property (@(posedge clk) disable iff (rst)
    pc_link[1:0] == pc_q[1:0]);
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .JFLD_W(JFLD_W)) u_chk (
  .clk(clk), .rst(rst), .br_disp(br_disp), .jmp_field(jmp_field),
  .br_kind(br_kind), .jmp_en(jmp_en), .alu_zero(alu_zero),
  .pc_q(pc_q), .pc_link(pc_link), .br_taken(br_taken), .nsrc(nsrc)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] br_disp = '0;
  logic [25:0] jmp_field = '0;
  logic [1:0]  br_kind = '0;
  logic        jmp_en = 1'b0;
  logic        alu_zero = 1'b0;
  logic [31:0] pc_q, pc_link;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] model_pc = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pc_sequencer uut (
    .clk(clk), .rst(rst), .br_disp(br_disp), .jmp_field(jmp_field),
    .br_kind(br_kind), .jmp_en(jmp_en), .alu_zero(alu_zero),
    .pc_q(pc_q), .pc_link(pc_link)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // driver: apply one instruction's fields and queue the address due after the edge
  task automatic step(input bit r, input logic [1:0] kind, input bit z, input bit j,
                      input logic [15:0] d, input logic [25:0] f, input string req);
    logic [31:0] nxt;
    logic [31:0] wofs;
    bit hit;
    @(negedge clk);
    rst = r; br_kind = kind; alu_zero = z; jmp_en = j; br_disp = d; jmp_field = f;
    #1;
    check("R2 link", pc_link, model_pc + 32'd4);
    wofs = {{14{d[15]}}, d, 2'b00};
    hit = (kind == 2'b10 && z) || (kind == 2'b11 && !z);
    if (r)        nxt = 32'h0;
    else if (j)   nxt = {model_pc[31:28], f, 2'b00};
    else if (hit) nxt = model_pc + 32'd4 + wofs;
    else          nxt = model_pc + 32'd4;
    exp_q.push_back(nxt);
    tag_q.push_back(req);
    model_pc = nxt;
  endtask

  // monitor: compare pc_q away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), pc_q, exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1, 2'b00, 0, 0, 16'h0, 26'h0, "R1 reset");
    step(1, 2'b10, 1, 1, 16'h5, 26'h77, "R1 reset held");
    step(0, 2'b00, 1, 0, 16'h0040, 26'h0, "R3 kind00");
    step(0, 2'b01, 0, 0, 16'h0040, 26'h0, "R3 kind01");
    step(0, 2'b10, 1, 0, 16'h0010, 26'h0, "R4 eq taken");
    step(0, 2'b10, 0, 0, 16'h0010, 26'h0, "R5 eq miss");
    step(0, 2'b11, 0, 0, 16'h0003, 26'h0, "R6 ne taken");
    step(0, 2'b11, 1, 0, 16'h0003, 26'h0, "R6 ne miss");
    step(0, 2'b10, 1, 0, 16'hFFFF, 26'h0, "R7 self");
    step(0, 2'b11, 0, 0, 16'hFFF0, 26'h0, "R7 back");
    step(0, 2'b00, 0, 1, 16'h0, 26'h3FFFFFF, "R8 jump");
    step(0, 2'b00, 0, 0, 16'h0, 26'h0, "R10 carry");
    step(0, 2'b10, 1, 1, 16'h0100, 26'h0000123, "R9 jump over eq");
    step(0, 2'b11, 0, 1, 16'h0100, 26'h0000200, "R9 jump over ne");
    step(0, 2'b01, 1, 0, 16'h7FFF, 26'h0, "R3 ignore");
    step(0, 2'b10, 1, 0, 16'h7FFF, 26'h0, "R4 max disp");
    step(1, 2'b00, 0, 0, 16'h0, 26'h0, "R1 mid reset");
    step(0, 2'b00, 0, 0, 16'h0, 26'h0, "R3 after reset");
    step(0, 2'b00, 0, 0, 16'h0, 26'h0, "R2 drain");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule